// File: doc/BRIEF.md
# Dual-Port Address Window Translator

This block sits between a core with separate instruction and data buses and the memories and devices behind them. Every cycle it takes one code-fetch address and one data address and maps each onto a physical target: internal RAM, program memory, or one of four external devices. Both ports are translated in the same cycle. Each port uses its own bank of four programmable windows. A window holds a lower bound, an upper bound, a relocation offset, a target code, a wait-state count and an enable bit.

Where windows overlap, the lowest-numbered matching window is used. An address that matches no window goes to the port's default target, unchanged. Access completion is signalled per port by a ready output, after the number of wait cycles set in the winning window. If both ports go to the same external device at once, the data access proceeds and the code fetch is held off until the data request is withdrawn.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset every window is disabled. A code address then maps to itself with target code 1 (program memory), a data address maps to itself with target code 0 (RAM), and a request on either port sees ready in the same cycle.
- R2: A window matches only while its enable bit is set and lower bound <= address <= upper bound. Both bounds are inclusive.
- R3: For a matching window, the physical address is (address - lower bound + offset) modulo 2^24, and the target is the window's target code.
- R4: When several windows of one port match, the one with the lowest index supplies the translation.
- R5: An address with no matching window passes through unchanged. Its target is program memory (code port) or RAM (data port), with zero wait states.
- R6: The code port and the data port translate concurrently. Each uses only its own window bank, so one address can map differently on the two ports.
- R7: A request whose window holds wait count W (4 bits, 0 to 15) sees ready W cycles after the request is presented. The request must be held until ready. With W = 0, ready comes in the same cycle.
- R8: When both ports request the same external device (target codes 4 + k, k = 0 to 3) in the same cycle, the data port proceeds. Code ready stays low and its wait count is frozen. Counting resumes once the data request drops.
- R9: Requests to different devices, or to internal targets, never stall each other.
- R10: A configuration write stores cfg_wdata into the window selected by cfg_bank (0 code, 1 data), cfg_win and cfg_field, and takes effect from the next cycle. The cfg_field codes are: 0 lower bound, 1 upper bound, 2 offset, 3 control. The control word holds target code in bits [2:0], wait count in bits [6:3] and enable in bit [7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 1 | Window bank select: 0 code, 1 data |
| cfg_win | input | 2 | Window index |
| cfg_field | input | 2 | Field select |
| cfg_wdata | input | 24 | Configuration write data |
| code_req | input | 1 | Code fetch request |
| code_addr | input | 24 | Code logical address |
| code_paddr | output | 24 | Code physical address |
| code_tgt | output | 3 | Code target code |
| code_ready | output | 1 | Code access complete |
| data_req | input | 1 | Data access request |
| data_addr | input | 24 | Data logical address |
| data_paddr | output | 24 | Data physical address |
| data_tgt | output | 3 | Data target code |
| data_ready | output | 1 | Data access complete |

## Verification
Physical address and target code are combinational, so they are due in the same cycle as the address. The bench drives addresses just after a rising edge and samples them at the following falling edge. Ready is due a number of rising edges after the request equal to the window's wait count, or later by the length of a stall. For each case the bench counts the edges since the request. It checks that ready is low at every falling edge before the due edge and high at the falling edge right after it. A configuration write is registered, so its effect is sampled in the cycle after the write edge.

// File: rtl/axu_pkg.sv
package axu_pkg;
    localparam int ADDR_W  = 24;
    localparam int WAIT_W  = 4;
    localparam int TGT_W   = 3;
    localparam int NWIN    = 4;

    localparam logic [TGT_W-1:0] TGT_RAM  = 3'd0;
    localparam logic [TGT_W-1:0] TGT_PROG = 3'd1;
    // bit [TGT_W-1] set marks an external device
    localparam int EXT_BIT = TGT_W - 1;

    typedef enum logic [1:0] {
        FLD_LO   = 2'd0,
        FLD_HI   = 2'd1,
        FLD_OFFS = 2'd2,
        FLD_CTRL = 2'd3
    } fld_e;

    typedef struct packed {
        logic              en;
        logic [WAIT_W-1:0] ws;
        logic [TGT_W-1:0]  tgt;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [ADDR_W-1:0] offs;
    } win_t;
endpackage

// File: rtl/axu_win_bank.sv
module axu_win_bank
    import axu_pkg::*;
#(
    parameter  int NWIN  = axu_pkg::NWIN,
    localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDX_W-1:0]      win,
    input  logic [1:0]            field,
    input  logic [ADDR_W-1:0]     wdata,
    output win_t [NWIN-1:0]       wins_o
);
    win_t [NWIN-1:0] wins_d, wins_q;

    always_comb begin
        wins_d = wins_q;
        if (we && (int'(win) < NWIN)) begin
            case (fld_e'(field))
                FLD_LO:   wins_d[win].lo   = wdata;
                FLD_HI:   wins_d[win].hi   = wdata;
                FLD_OFFS: wins_d[win].offs = wdata;
                default: begin
                    wins_d[win].tgt = wdata[TGT_W-1:0];
                    wins_d[win].ws  = wdata[TGT_W +: WAIT_W];
                    wins_d[win].en  = wdata[TGT_W + WAIT_W];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wins_q <= '0;
        else        wins_q <= wins_d;
    end

    assign wins_o = wins_q;

    // R10
    ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && field == FLD_CTRL) |=>
            (wins_q[$past(win)].en == $past(wdata[TGT_W + WAIT_W]) &&
             wins_q[$past(win)].ws == $past(wdata[TGT_W +: WAIT_W])));

    // R10
    lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && field == FLD_LO) |=> wins_q[$past(win)].lo == $past(wdata));
endmodule

// File: rtl/axu_lookup.sv
module axu_lookup
    import axu_pkg::*;
#(
    parameter int               NWIN    = axu_pkg::NWIN,
    parameter logic [TGT_W-1:0] DEF_TGT = axu_pkg::TGT_RAM
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  win_t [NWIN-1:0]   wins_i,
    output logic [ADDR_W-1:0] paddr_o,
    output logic [TGT_W-1:0]  tgt_o,
    output logic [WAIT_W-1:0] ws_o,
    output logic              hit_o,
    output logic [NWIN-1:0]   grant_o
);
    logic [NWIN-1:0] in_rng;

    for (genvar i = 0; i < NWIN; i++) begin : g_match
        assign in_rng[i] = wins_i[i].en &&
                           (addr_i >= wins_i[i].lo) &&
                           (addr_i <= wins_i[i].hi);
        if (i == 0) begin : g_first
            assign grant_o[i] = in_rng[i];
        end else begin : g_rest
            assign grant_o[i] = in_rng[i] && !(|in_rng[i-1:0]);
        end
    end

    assign hit_o = |in_rng;

    always_comb begin
        paddr_o = addr_i;
        tgt_o   = DEF_TGT;
        ws_o    = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (grant_o[i]) begin
                paddr_o = addr_i - wins_i[i].lo + wins_i[i].offs;
                tgt_o   = wins_i[i].tgt;
                ws_o    = wins_i[i].ws;
            end
        end
    end
endmodule

// File: rtl/axu_wait_ctr.sv
module axu_wait_ctr
    import axu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              hold,
    input  logic [WAIT_W-1:0] ws,
    output logic              ready
);
    typedef struct packed {
        logic [WAIT_W-1:0] cnt;
    } wst_t;

    wst_t st_d, st_q;

    assign ready = req && !hold && (st_q.cnt == ws);

    always_comb begin
        st_d = st_q;
        if (!req || ready) st_d.cnt = '0;
        else if (!hold)    st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    ws_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !hold && !ready) |=> st_q.cnt == WAIT_W'($past(st_q.cnt) + 1'b1));

    // R7
    ws_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> st_q.cnt == '0);

    // R8
    ws_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && hold) |=> $stable(st_q.cnt));
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
    import axu_pkg::*;
#(
    parameter  int NWIN  = axu_pkg::NWIN,
    localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_bank,
    input  logic [IDX_W-1:0]  cfg_win,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              code_req,
    input  logic [ADDR_W-1:0] code_addr,
    output logic [ADDR_W-1:0] code_paddr,
    output logic [TGT_W-1:0]  code_tgt,
    output logic              code_ready,
    input  logic              data_req,
    input  logic [ADDR_W-1:0] data_addr,
    output logic [ADDR_W-1:0] data_paddr,
    output logic [TGT_W-1:0]  data_tgt,
    output logic              data_ready
);
    win_t [NWIN-1:0]   code_wins, data_wins;
    logic [WAIT_W-1:0] code_ws, data_ws;
    logic              code_hit, data_hit;
    logic [NWIN-1:0]   code_grant, data_grant;
    logic              code_hold;

    axu_win_bank #(.NWIN(NWIN)) i_code_bank (
        .clk(clk), .rst_n(rst_n), .we(cfg_we && !cfg_bank),
        .win(cfg_win), .field(cfg_field), .wdata(cfg_wdata), .wins_o(code_wins)
    );

    axu_win_bank #(.NWIN(NWIN)) i_data_bank (
        .clk(clk), .rst_n(rst_n), .we(cfg_we && cfg_bank),
        .win(cfg_win), .field(cfg_field), .wdata(cfg_wdata), .wins_o(data_wins)
    );

    axu_lookup #(.NWIN(NWIN), .DEF_TGT(TGT_PROG)) i_code_lookup (
        .addr_i(code_addr), .wins_i(code_wins), .paddr_o(code_paddr),
        .tgt_o(code_tgt), .ws_o(code_ws), .hit_o(code_hit), .grant_o(code_grant)
    );

    axu_lookup #(.NWIN(NWIN), .DEF_TGT(TGT_RAM)) i_data_lookup (
        .addr_i(data_addr), .wins_i(data_wins), .paddr_o(data_paddr),
        .tgt_o(data_tgt), .ws_o(data_ws), .hit_o(data_hit), .grant_o(data_grant)
    );

    // data side wins a same-device conflict; code side waits
    assign code_hold = code_req && data_req &&
                       code_tgt[EXT_BIT] && (code_tgt == data_tgt);

    axu_wait_ctr i_code_wait (
        .clk(clk), .rst_n(rst_n), .req(code_req), .hold(code_hold),
        .ws(code_ws), .ready(code_ready)
    );

    axu_wait_ctr i_data_wait (
        .clk(clk), .rst_n(rst_n), .req(data_req), .hold(1'b0),
        .ws(data_ws), .ready(data_ready)
    );

    // R8
    data_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_req && data_req && code_tgt[EXT_BIT] && code_tgt == data_tgt) |-> !code_ready);

    // R5
    code_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_hit |-> (code_paddr == code_addr && code_tgt == TGT_PROG));

    // R5
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_hit |-> (data_paddr == data_addr && data_tgt == TGT_RAM));

    // R4
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(code_grant) && $onehot0(data_grant));

    // R9
    data_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req && data_ws == '0) |-> data_ready);
endmodule

// File: tb/test_addr_window_xlate.sv
module test_addr_window_xlate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_bank = 1'b0;
    logic [1:0]  cfg_win = '0;
    logic [1:0]  cfg_field = '0;
    logic [23:0] cfg_wdata = '0;
    logic        code_req = 1'b0;
    logic [23:0] code_addr = '0;
    logic [23:0] code_paddr;
    logic [2:0]  code_tgt;
    logic        code_ready;
    logic        data_req = 1'b0;
    logic [23:0] data_addr = '0;
    logic [23:0] data_paddr;
    logic [2:0]  data_tgt;
    logic        data_ready;

    int checks = 0;
    int errors = 0;

    addr_window_xlate i_addr_window_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_win(cfg_win), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .code_req(code_req), .code_addr(code_addr), .code_paddr(code_paddr),
        .code_tgt(code_tgt), .code_ready(code_ready),
        .data_req(data_req), .data_addr(data_addr), .data_paddr(data_paddr),
        .data_tgt(data_tgt), .data_ready(data_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [23:0] ca;
        logic [23:0] da;
        logic [23:0] cp;
        logic [2:0]  ct;
        logic [23:0] dp;
        logic [2:0]  dt;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{24'h001000, 24'h002000, 24'h400000, 3'd4, 24'h600000, 3'd4},
        '{24'h001FFF, 24'h0020FF, 24'h400FFF, 3'd4, 24'h6000FF, 3'd4},
        '{24'h002000, 24'h002100, 24'h500800, 3'd5, 24'h800100, 3'd7},
        '{24'h000FFF, 24'h001FFF, 24'h000FFF, 3'd1, 24'h001FFF, 3'd0},
        '{24'h002FFF, 24'h003FFF, 24'h5017FF, 3'd5, 24'h700FFF, 3'd6},
        '{24'h003000, 24'h004000, 24'h003000, 3'd1, 24'h004000, 3'd0},
        '{24'h018000, 24'h003000, 24'h008100, 3'd0, 24'h700000, 3'd6},
        '{24'h001800, 24'h0020FE, 24'h400800, 3'd4, 24'h6000FE, 3'd4},
        '{24'hFFF200, 24'hFFF200, 24'hFFF200, 3'd1, 24'h000100, 3'd0}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic wr(input logic bank, input logic [1:0] win,
                      input logic [1:0] fld, input logic [23:0] val);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_bank = bank; cfg_win = win; cfg_field = fld; cfg_wdata = val;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic win_set(input logic bank, input logic [1:0] win, input logic [23:0] lo,
                           input logic [23:0] hi, input logic [23:0] offs, input logic [7:0] ctrl);
        wr(bank, win, 2'd0, lo);
        wr(bank, win, 2'd1, hi);
        wr(bank, win, 2'd2, offs);
        wr(bank, win, 2'd3, {16'h0, ctrl});
    endtask

    task automatic step;
        @(posedge clk); #1;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, all windows off, zero wait
        code_addr = 24'h001000; data_addr = 24'h002000;
        code_req = 1'b1; data_req = 1'b1;
        @(negedge clk);
        chk("R1 code paddr", code_paddr, 24'h001000);
        chk("R1 code tgt", code_tgt, 3'd1);
        chk("R1 data paddr", data_paddr, 24'h002000);
        chk("R1 data tgt", data_tgt, 3'd0);
        chk("R1 code ready", code_ready, 1'b1);
        chk("R1 data ready", data_ready, 1'b1);
        step();
        code_req = 1'b0; data_req = 1'b0;

        // R10: program both banks
        win_set(1'b0, 2'd0, 24'h001000, 24'h001FFF, 24'h400000, 8'h94);
        win_set(1'b0, 2'd1, 24'h001800, 24'h002FFF, 24'h500000, 8'h85);
        win_set(1'b0, 2'd2, 24'h010000, 24'h01FFFF, 24'h000100, 8'h88);
        win_set(1'b0, 2'd3, 24'h000000, 24'hFFFFFF, 24'h123456, 8'h07);
        win_set(1'b1, 2'd0, 24'h002000, 24'h0020FF, 24'h600000, 8'h9C);
        win_set(1'b1, 2'd1, 24'h003000, 24'h003FFF, 24'h700000, 8'h86);
        win_set(1'b1, 2'd2, 24'h002000, 24'h002FFF, 24'h800000, 8'h87);
        win_set(1'b1, 2'd3, 24'hFFF000, 24'hFFFFFF, 24'hFFFF00, 8'h80);

        // R2 R3 R4 R5 R6: translation table
        for (int i = 0; i < NV; i++) begin
            step();
            code_addr = VECS[i].ca; data_addr = VECS[i].da;
            @(negedge clk);
            chk($sformatf("R2/R3/R4/R5/R6 vec %0d code paddr", i), code_paddr, VECS[i].cp);
            chk($sformatf("R2/R3/R4/R5/R6 vec %0d code tgt", i), code_tgt, VECS[i].ct);
            chk($sformatf("R2/R3/R4/R5/R6 vec %0d data paddr", i), data_paddr, VECS[i].dp);
            chk($sformatf("R2/R3/R4/R5/R6 vec %0d data tgt", i), data_tgt, VECS[i].dt);
        end

        // R7: code alone, window wait 2
        step();
        code_addr = 24'h001000; code_req = 1'b1;
        @(negedge clk); chk("R7 code ws2 edge0", code_ready, 1'b0);
        step(); @(negedge clk); chk("R7 code ws2 edge1", code_ready, 1'b0);
        step(); @(negedge clk); chk("R7 code ws2 edge2", code_ready, 1'b1);
        step(); code_req = 1'b0;

        // R7: code window wait 1 to RAM
        code_addr = 24'h018000; code_req = 1'b1;
        @(negedge clk); chk("R7 code ws1 edge0", code_ready, 1'b0);
        step(); @(negedge clk); chk("R7 code ws1 edge1", code_ready, 1'b1);
        step(); code_req = 1'b0;

        // R8: both ports on external device 0; data ws3, code ws2
        code_addr = 24'h001000; data_addr = 24'h002000;
        code_req = 1'b1; data_req = 1'b1;
        @(negedge clk);
        chk("R8 code stalled edge0", code_ready, 1'b0);
        chk("R8 data edge0", data_ready, 1'b0);
        step(); @(negedge clk); chk("R8 code stalled edge1", code_ready, 1'b0);
        step(); @(negedge clk); chk("R8 code stalled edge2", code_ready, 1'b0);
        chk("R8 data edge2", data_ready, 1'b0);
        step(); @(negedge clk); chk("R8 code stalled edge3", code_ready, 1'b0);
        chk("R8 data done edge3", data_ready, 1'b1);
        step(); data_req = 1'b0;
        @(negedge clk); chk("R8 code resumes edge0", code_ready, 1'b0);
        step(); @(negedge clk); chk("R8 code resumes edge1", code_ready, 1'b0);
        step(); @(negedge clk); chk("R8 code resumes edge2", code_ready, 1'b1);
        step(); code_req = 1'b0;

        // R9: code ext1 ws0 while data ext0 ws3
        code_addr = 24'h002000; data_addr = 24'h002000;
        code_req = 1'b1; data_req = 1'b1;
        @(negedge clk);
        chk("R9 code not stalled", code_ready, 1'b1);
        chk("R9 data waiting", data_ready, 1'b0);
        step(); code_req = 1'b0; data_req = 1'b0;

        // R7: maximum wait count 15 on data window 2
        wr(1'b1, 2'd2, 2'd3, 24'h0000FF);
        data_addr = 24'h002100; data_req = 1'b1;
        repeat (14) step();
        @(negedge clk); chk("R7 ws15 edge14", data_ready, 1'b0);
        step(); @(negedge clk); chk("R7 ws15 edge15", data_ready, 1'b1);
        step(); data_req = 1'b0;

        // R10 R2: disabling data window 1 takes effect next cycle
        data_addr = 24'h003000;
        @(negedge clk); chk("R10 before disable tgt", data_tgt, 3'd6);
        wr(1'b1, 2'd1, 2'd3, 24'h000006);
        @(negedge clk);
        chk("R10 disabled window paddr", data_paddr, 24'h003000);
        chk("R10 disabled window tgt", data_tgt, 3'd0);

        step();
        finish_run();
    end
endmodule